// File: doc/BRIEF.md
# Dual-ADC Ping-Pong Sample Sequencer

This block times the current and bus-voltage samples of a three-phase inverter. A strobe from the PWM at the start of each period starts a counter in system-clock cycles. After a fixed delay, a first trigger makes both converters sample together. One of them takes a phase current from its first channel slot and the other takes a second phase current from its second slot. A second trigger follows after one conversion time and swaps the slots. The first converter then samples the DC bus voltage and the second samples the remaining phase current.

The first delay is half the PWM period plus half the dead time, which places the current samples in the middle of the all-low switching state. The sector of the voltage vector is latched on each start strobe. It picks the pair of phases whose low-side conduction window is long, so that the short window is never sampled.

Each converter is modelled as a start pulse, a channel code and a one-cycle done pulse with data. Results go into four registers. An interrupt is raised once the first conversion pair has completed, without waiting for the second pair. A read strobe clears the completion flags.

Top module: `adc_pingpong_seq`

## Requirements
- R1: After reset no trigger is active, `irq_o`, `cc_b_o` and `ovr_o` are 0, all four result registers are 0, `adc0_ch_o` is 9 and `adc1_ch_o` is 6.
- R2: `trig_a_o` is high for one cycle, exactly HALF_PER + DEAD/2 cycles after the clock edge that samples `sync_i` high.
- R3: `trig_b_o` is high for one cycle, exactly CONV_GAP cycles after `trig_a_o`. The two triggers never coincide.
- R4: During `trig_a_o`, `adc0_ch_o` carries converter 0's first-slot code and `adc1_ch_o` carries converter 1's second-slot code. During `trig_b_o`, `adc0_ch_o` carries converter 0's second-slot code, which is always 5 (bus voltage), and `adc1_ch_o` carries converter 1's first-slot code.
- R5: Channel codes by sector. For sectors 2 and 3, converter 0 gets first slot 7 and converter 1 gets second slot 8 and first slot 6. For sectors 4 and 5, converter 0 gets first slot 7 and converter 1 gets second slot 6 and first slot 8. For sectors 1 and 6 and the codes 0 and 7, converter 0 gets first slot 9 and converter 1 gets second slot 6 and first slot 4.
- R6: `sector_i` is sampled only on the edge that accepts `sync_i`. A change at any other time leaves the channel codes of the running sequence unchanged.
- R7: A done pulse stores its data in the result register of the slot that converter used at the latest trigger. For converter 0 that is `res0a_o` after trigger A and `res0b_o` after trigger B. For converter 1 it is `res1b_o` after trigger A and `res1a_o` after trigger B. No other register changes.
- R8: `irq_o` rises one cycle after the later of the two done pulses that follow trigger A, independently of the pair that follows trigger B.
- R9: `cc_b_o` rises one cycle after the later of the two done pulses that follow trigger B.
- R10: A one-cycle `rd_i` clears `irq_o` and `cc_b_o` on the next edge. Both flags otherwise hold.
- R11: A `sync_i` accepted while a sequence has not yet issued trigger B restarts the delay count and sets `ovr_o`. `ovr_o` stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sync_i | input | 1 | Start-of-period strobe from the PWM |
| sector_i | input | 3 | Voltage-vector sector, 1 to 6 |
| rd_i | input | 1 | Result read strobe, clears completion flags |
| trig_a_o | output | 1 | First conversion trigger to both converters |
| trig_b_o | output | 1 | Second conversion trigger to both converters |
| adc0_ch_o | output | 5 | Channel code presented to converter 0 |
| adc1_ch_o | output | 5 | Channel code presented to converter 1 |
| done0_i | input | 1 | Converter 0 conversion done |
| data0_i | input | DATA_W | Converter 0 result |
| done1_i | input | 1 | Converter 1 conversion done |
| data1_i | input | DATA_W | Converter 1 result |
| res0a_o | output | DATA_W | Converter 0 first-slot result |
| res0b_o | output | DATA_W | Converter 0 second-slot result |
| res1a_o | output | DATA_W | Converter 1 first-slot result |
| res1b_o | output | DATA_W | Converter 1 second-slot result |
| irq_o | output | 1 | Current pair complete (interrupt request) |
| cc_b_o | output | 1 | Second pair complete |
| ovr_o | output | 1 | Sticky sequence overrun |

## Verification
The bench builds the block with HALF_PER=20, DEAD=6 and CONV_GAP=9. Trigger A therefore lands 23 cycles after the strobe and trigger B 32 cycles after it. A whole sequence then fits in about forty cycles, so every sector code, including the two invalid ones, and a mid-sequence restart are all exercised in a short run. The modelled converters answer after 3 and 5 cycles, inside the 9-cycle gap. This makes the interrupt visibly precede the second pair, and it lets the staggered done pulses of the two converters show the later-of-two rule.

// File: rtl/adc_pp_pkg.sv
package adc_pp_pkg;
  localparam int CH_W = 5;
  typedef logic [CH_W-1:0] ch_t;

  localparam ch_t C0_IA  = 5'd7;
  localparam ch_t C0_IC  = 5'd9;
  localparam ch_t C0_VDC = 5'd5;
  localparam ch_t C1_IA  = 5'd4;
  localparam ch_t C1_IB  = 5'd6;
  localparam ch_t C1_IC  = 5'd8;

  // a = first slot, b = second slot, per converter
  typedef struct packed {
    ch_t a0;
    ch_t b0;
    ch_t a1;
    ch_t b1;
  } ch_set_t;

  function automatic ch_set_t sector_map(input logic [2:0] sec);
    ch_set_t m;
    m.b0 = C0_VDC;
    case (sec)
      3'd2, 3'd3: begin m.a0 = C0_IA; m.b1 = C1_IC; m.a1 = C1_IB; end
      3'd4, 3'd5: begin m.a0 = C0_IA; m.b1 = C1_IB; m.a1 = C1_IC; end
      default:    begin m.a0 = C0_IC; m.b1 = C1_IB; m.a1 = C1_IA; end
    endcase
    return m;
  endfunction
endpackage

// File: rtl/adc_pp_timer.sv
module adc_pp_timer #(
  parameter int DLY_A = 23,
  parameter int DLY_B = 32,
  parameter int CNT_W = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sync_i,
  output logic trig_a_o,
  output logic trig_b_o,
  output logic phase_b_o,
  output logic ovr_o
);
  logic             run_q, pb_q, ovr_q;
  logic [CNT_W-1:0] cnt_q;

  assign trig_a_o  = run_q && (cnt_q == CNT_W'(DLY_A));
  assign trig_b_o  = run_q && (cnt_q == CNT_W'(DLY_B));
  assign phase_b_o = pb_q;
  assign ovr_o     = ovr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
      pb_q  <= 1'b0;
      ovr_q <= 1'b0;
      cnt_q <= '0;
    end else if (sync_i) begin
      if (run_q && !trig_b_o) ovr_q <= 1'b1;
      run_q <= 1'b1;
      pb_q  <= 1'b0;
      cnt_q <= '0;
    end else if (run_q) begin
      cnt_q <= cnt_q + 1'b1;
      if (trig_a_o) pb_q  <= 1'b1;
      if (trig_b_o) run_q <= 1'b0;
    end
  end
endmodule

// File: rtl/adc_pp_chmap.sv
module adc_pp_chmap
  import adc_pp_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       load_i,
  input  logic [2:0] sector_i,
  input  logic       phase_b_i,
  output ch_t        adc0_ch_o,
  output ch_t        adc1_ch_o
);
  logic [2:0] sec_q;
  ch_set_t    cs;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     sec_q <= 3'd0;
    else if (load_i) sec_q <= sector_i;
  end

  assign cs = sector_map(sec_q);

  // ping-pong: converter 0 walks a->b, converter 1 walks b->a
  assign adc0_ch_o = phase_b_i ? cs.b0 : cs.a0;
  assign adc1_ch_o = phase_b_i ? cs.a1 : cs.b1;
endmodule

// File: rtl/adc_pp_results.sv
module adc_pp_results #(
  parameter int DATA_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              trig_a_i,
  input  logic              trig_b_i,
  input  logic              rd_i,
  input  logic              done0_i,
  input  logic [DATA_W-1:0] data0_i,
  input  logic              done1_i,
  input  logic [DATA_W-1:0] data1_i,
  output logic [DATA_W-1:0] res_a_o [2],
  output logic [DATA_W-1:0] res_b_o [2],
  output logic              irq_o,
  output logic              cc_b_o
);
  localparam int LANES = 2;

  logic                    slot_q;
  logic [LANES-1:0]        done;
  logic [DATA_W-1:0]       din [LANES];
  logic [LANES-1:0]        got_pa_q, got_pb_q, nxt_pa, nxt_pb;
  logic                    fin_a, fin_b, irq_q, ccb_q;

  assign done   = {done1_i, done0_i};
  assign din[0] = data0_i;
  assign din[1] = data1_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       slot_q <= 1'b0;
    else if (trig_b_i) slot_q <= 1'b1;
    else if (trig_a_i) slot_q <= 1'b0;
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    // lane g uses register (pair ^ g): lane 0 A-pair->a, lane 1 A-pair->b
    localparam logic SWAP = (g != 0);
    logic [DATA_W-1:0] ra_q, rb_q;
    logic              reg_sel;

    assign reg_sel   = slot_q ^ SWAP;
    assign nxt_pa[g] = got_pa_q[g] | (done[g] & ~slot_q);
    assign nxt_pb[g] = got_pb_q[g] | (done[g] &  slot_q);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ra_q <= '0;
        rb_q <= '0;
      end else if (done[g]) begin
        if (reg_sel) rb_q <= din[g];
        else         ra_q <= din[g];
      end
    end

    assign res_a_o[g] = ra_q;
    assign res_b_o[g] = rb_q;
  end

  assign fin_a = (&nxt_pa) & ~(&got_pa_q) & ~trig_a_i;
  assign fin_b = (&nxt_pb) & ~(&got_pb_q) & ~trig_b_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      got_pa_q <= '0;
      got_pb_q <= '0;
      irq_q    <= 1'b0;
      ccb_q    <= 1'b0;
    end else begin
      got_pa_q <= trig_a_i ? '0 : nxt_pa;
      got_pb_q <= trig_b_i ? '0 : nxt_pb;
      if (fin_a)     irq_q <= 1'b1;
      else if (rd_i) irq_q <= 1'b0;
      if (fin_b)     ccb_q <= 1'b1;
      else if (rd_i) ccb_q <= 1'b0;
    end
  end

  assign irq_o  = irq_q;
  assign cc_b_o = ccb_q;
endmodule

// File: rtl/adc_pingpong_seq.sv
module adc_pingpong_seq
  import adc_pp_pkg::*;
#(
  parameter int HALF_PER = 1600,
  parameter int DEAD     = 16,
  parameter int CONV_GAP = 118,
  parameter int DATA_W   = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sync_i,
  input  logic [2:0]        sector_i,
  input  logic              rd_i,
  output logic              trig_a_o,
  output logic              trig_b_o,
  output logic [CH_W-1:0]   adc0_ch_o,
  output logic [CH_W-1:0]   adc1_ch_o,
  input  logic              done0_i,
  input  logic [DATA_W-1:0] data0_i,
  input  logic              done1_i,
  input  logic [DATA_W-1:0] data1_i,
  output logic [DATA_W-1:0] res0a_o,
  output logic [DATA_W-1:0] res0b_o,
  output logic [DATA_W-1:0] res1a_o,
  output logic [DATA_W-1:0] res1b_o,
  output logic              irq_o,
  output logic              cc_b_o,
  output logic              ovr_o
);
  localparam int DLY_A = HALF_PER + DEAD / 2;
  localparam int DLY_B = DLY_A + CONV_GAP;
  localparam int CNT_W = $clog2(DLY_B + 1) + 1;

  logic              phase_b;
  logic [DATA_W-1:0] res_a [2];
  logic [DATA_W-1:0] res_b [2];

  adc_pp_timer #(
    .DLY_A (DLY_A),
    .DLY_B (DLY_B),
    .CNT_W (CNT_W)
  ) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sync_i    (sync_i),
    .trig_a_o  (trig_a_o),
    .trig_b_o  (trig_b_o),
    .phase_b_o (phase_b),
    .ovr_o     (ovr_o)
  );

  adc_pp_chmap u_chmap (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (sync_i),
    .sector_i  (sector_i),
    .phase_b_i (phase_b),
    .adc0_ch_o (adc0_ch_o),
    .adc1_ch_o (adc1_ch_o)
  );

  adc_pp_results #(.DATA_W(DATA_W)) u_res (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .trig_a_i (trig_a_o),
    .trig_b_i (trig_b_o),
    .rd_i     (rd_i),
    .done0_i  (done0_i),
    .data0_i  (data0_i),
    .done1_i  (done1_i),
    .data1_i  (data1_i),
    .res_a_o  (res_a),
    .res_b_o  (res_b),
    .irq_o    (irq_o),
    .cc_b_o   (cc_b_o)
  );

  assign res0a_o = res_a[0];
  assign res0b_o = res_b[0];
  assign res1a_o = res_a[1];
  assign res1b_o = res_b[1];
endmodule

// File: rtl/adc_pingpong_seq_chk.sv
module adc_pingpong_seq_chk #(
  parameter int CONV_GAP = 118,
  parameter int DATA_W   = 12
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              rd_i,
  input logic              trig_a_o,
  input logic              trig_b_o,
  input logic [4:0]        adc0_ch_o,
  input logic              done0_i,
  input logic [DATA_W-1:0] res0a_o,
  input logic              irq_o,
  input logic              ovr_o
);
  logic [15:0] gap_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               gap_cnt <= '0;
    else if (trig_a_o)         gap_cnt <= '0;
    else if (gap_cnt != '1)    gap_cnt <= gap_cnt + 1'b1;
  end

  AST_TRIG_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(trig_a_o && trig_b_o)); // R3
  AST_GAP_B: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_b_o |-> gap_cnt == 16'(CONV_GAP - 1)); // R3
  AST_VDC_ON_B: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_b_o |-> adc0_ch_o == 5'd5); // R4
  AST_RES_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done0_i |=> $stable(res0a_o)); // R7
  AST_IRQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !rd_i) |=> irq_o); // R10
  AST_OVR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovr_o |=> ovr_o); // R11
endmodule

bind adc_pingpong_seq adc_pingpong_seq_chk #(
  .CONV_GAP (CONV_GAP),
  .DATA_W   (DATA_W)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .rd_i      (rd_i),
  .trig_a_o  (trig_a_o),
  .trig_b_o  (trig_b_o),
  .adc0_ch_o (adc0_ch_o),
  .done0_i   (done0_i),
  .res0a_o   (res0a_o),
  .irq_o     (irq_o),
  .ovr_o     (ovr_o)
);

// File: tb/tb_adc_pingpong_seq.sv
module tb_adc_pingpong_seq;
  localparam int HP    = 20;
  localparam int DT    = 6;
  localparam int GAP   = 9;
  localparam int DW    = 12;
  localparam int DLY_A = HP + DT / 2;
  localparam int LAT0  = 3;
  localparam int LAT1  = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          sync_i = 1'b0;
  logic [2:0]    sector_i = 3'd0;
  logic          rd_i = 1'b0;
  logic          trig_a_o, trig_b_o;
  logic [4:0]    adc0_ch_o, adc1_ch_o;
  logic          done0_i = 1'b0, done1_i = 1'b0;
  logic [DW-1:0] data0_i = '0, data1_i = '0;
  logic [DW-1:0] res0a_o, res0b_o, res1a_o, res1b_o;
  logic          irq_o, cc_b_o, ovr_o;

  adc_pingpong_seq #(
    .HALF_PER (HP), .DEAD (DT), .CONV_GAP (GAP), .DATA_W (DW)
  ) dut (
    .clk_i (clk), .rst_ni (rst_n), .sync_i (sync_i), .sector_i (sector_i),
    .rd_i (rd_i), .trig_a_o (trig_a_o), .trig_b_o (trig_b_o),
    .adc0_ch_o (adc0_ch_o), .adc1_ch_o (adc1_ch_o),
    .done0_i (done0_i), .data0_i (data0_i), .done1_i (done1_i), .data1_i (data1_i),
    .res0a_o (res0a_o), .res0b_o (res0b_o), .res1a_o (res1a_o), .res1b_o (res1b_o),
    .irq_o (irq_o), .cc_b_o (cc_b_o), .ovr_o (ovr_o)
  );

  always #4 clk = ~clk;

  int nchk = 0;
  int nfail = 0;
  int cyc = 0;
  logic [3:0] tag = 4'd1;

  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    bit is_b;
    int ch0;
    int ch1;
    int at;
  } exp_t;
  exp_t q[$];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] pat(input logic [3:0] t, input bit b, input int ch);
    return {t, b, 2'b00, 5'(ch)};
  endfunction

  // R5 expected channel table
  task automatic exp_map(input int sec, output int a0, output int b1, output int a1);
    case (sec)
      2, 3:    begin a0 = 7; b1 = 8; a1 = 6; end
      4, 5:    begin a0 = 7; b1 = 6; a1 = 8; end
      default: begin a0 = 9; b1 = 6; a1 = 4; end
    endcase
  endtask

  // monitor: pops expected triggers
  always @(negedge clk) begin
    if (rst_n && (trig_a_o || trig_b_o)) begin
      if (q.size() == 0) begin
        chk(1'b0, "R2 R3 unexpected trigger", cyc, -1);
      end else begin
        exp_t e;
        e = q.pop_front();
        chk(trig_b_o == e.is_b, "R2 R3 trigger kind", int'(trig_b_o), int'(e.is_b));
        chk(cyc == e.at, e.is_b ? "R3 trigger B cycle" : "R2 trigger A cycle", cyc, e.at);
        chk(int'(adc0_ch_o) == e.ch0, "R4 R5 R6 adc0 channel", int'(adc0_ch_o), e.ch0);
        chk(int'(adc1_ch_o) == e.ch1, "R4 R5 R6 adc1 channel", int'(adc1_ch_o), e.ch1);
      end
    end
  end

  // converter model
  int d0 = 0, d1 = 0;
  logic [DW-1:0] p0, p1;
  always @(negedge clk) begin
    done0_i = (d0 == 1);
    if (d0 == 1) data0_i = p0;
    if (d0 != 0) d0--;
    done1_i = (d1 == 1);
    if (d1 == 1) data1_i = p1;
    if (d1 != 0) d1--;
    if (rst_n && (trig_a_o || trig_b_o)) begin
      p0 = pat(tag, trig_b_o, int'(adc0_ch_o));
      p1 = pat(tag, trig_b_o, int'(adc1_ch_o));
      d0 = LAT0;
      d1 = LAT1;
    end
  end

  task automatic run_seq(input int sec);
    int a0, b1, a1, ta, tb;
    exp_map(sec, a0, b1, a1);
    @(negedge clk);
    sector_i = 3'(sec);
    sync_i = 1'b1;
    ta = cyc + 1 + DLY_A;
    tb = ta + GAP;
    q.push_back('{1'b0, a0, b1, ta});
    q.push_back('{1'b1, 5, a1, tb});
    @(negedge clk);
    sync_i = 1'b0;
    sector_i = ~3'(sec); // R6: ignored until next sync
    while (cyc < ta + LAT1) @(negedge clk);
    chk(irq_o == 1'b0, "R8 irq early", int'(irq_o), 0);
    @(negedge clk);
    chk(irq_o == 1'b1, "R8 irq after pair A", int'(irq_o), 1);
    chk(cc_b_o == 1'b0, "R9 cc_b before pair B", int'(cc_b_o), 0);
    chk(res0a_o == pat(tag, 1'b0, a0), "R7 res0a", int'(res0a_o), int'(pat(tag, 1'b0, a0)));
    chk(res1b_o == pat(tag, 1'b0, b1), "R7 res1b", int'(res1b_o), int'(pat(tag, 1'b0, b1)));
    while (cyc < tb + LAT1) @(negedge clk);
    chk(cc_b_o == 1'b0, "R9 cc_b early", int'(cc_b_o), 0);
    @(negedge clk);
    chk(cc_b_o == 1'b1, "R9 cc_b after pair B", int'(cc_b_o), 1);
    chk(res0b_o == pat(tag, 1'b1, 5), "R7 res0b", int'(res0b_o), int'(pat(tag, 1'b1, 5)));
    chk(res1a_o == pat(tag, 1'b1, a1), "R7 res1a", int'(res1a_o), int'(pat(tag, 1'b1, a1)));
    chk(res0a_o == pat(tag, 1'b0, a0), "R7 res0a kept", int'(res0a_o), int'(pat(tag, 1'b0, a0)));
    chk(irq_o == 1'b1, "R10 irq holds", int'(irq_o), 1);
    rd_i = 1'b1;
    @(negedge clk);
    rd_i = 1'b0;
    chk(irq_o == 1'b0, "R10 irq cleared", int'(irq_o), 0);
    chk(cc_b_o == 1'b0, "R10 cc_b cleared", int'(cc_b_o), 0);
    tag = tag + 4'd1;
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  endtask

  initial begin
    #(8 * 50000);
    nchk++;
    nfail++;
    $display("FAIL watchdog act=%0d exp=0", cyc);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(!trig_a_o && !trig_b_o, "R1 no trigger", int'({trig_a_o, trig_b_o}), 0);
    chk(!irq_o && !cc_b_o && !ovr_o, "R1 flags", int'({irq_o, cc_b_o, ovr_o}), 0);
    chk(adc0_ch_o == 5'd9, "R1 adc0 ch", int'(adc0_ch_o), 9);
    chk(adc1_ch_o == 5'd6, "R1 adc1 ch", int'(adc1_ch_o), 6);
    chk(res0a_o == 0 && res0b_o == 0 && res1a_o == 0 && res1b_o == 0,
        "R1 results", int'(res0a_o | res0b_o | res1a_o | res1b_o), 0);

    for (int s = 0; s < 8; s++) run_seq(s);
    chk(ovr_o == 1'b0, "R11 no overrun", int'(ovr_o), 0);

    // R11 restart before trigger B
    @(negedge clk);
    sector_i = 3'd2;
    sync_i = 1'b1;
    @(negedge clk);
    sync_i = 1'b0;
    repeat (8) @(negedge clk);
    chk(ovr_o == 1'b0, "R11 ovr before restart", int'(ovr_o), 0);
    run_seq(4);
    chk(ovr_o == 1'b1, "R11 ovr sticky", int'(ovr_o), 1);
    run_seq(1);
    chk(ovr_o == 1'b1, "R11 ovr still set", int'(ovr_o), 1);

    repeat (5) @(negedge clk);
    chk(q.size() == 0, "R2 R3 missing triggers", q.size(), 0);
    finish_run();
  end
endmodule